// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block produces the gate-drive signals for a three-phase inverter: one high-side and one low-side output for each of the phases A, B and C. A 16-bit timebase counts up from zero to a programmed period value and then back down. Each phase compares that count with its own duty value. As a result, every high-side pulse sits around the midpoint of the period. Software writes a period, three duty values and a control word through a simple write port. Period and duty values go into staged registers, and they move into the active registers only at defined load points. The sync output marks those load points.

The timebase is a state machine with three states. HOLD holds the counter at zero while the active period is zero. UP counts up. DOWN counts down. The transitions are as follows:
- HOLD goes to UP with the count at 1 once the active period is nonzero.
- UP goes to DOWN when the count reaches the period (the top). If the top is 1, UP stays in UP and the count returns to 0.
- DOWN goes to UP when the count reaches zero.
- UP goes to HOLD if the active period becomes zero.

Two input pins change how the outputs are driven. `pol_hi` selects active-high or active-low levels. `srm_n`, when driven low, selects a switched-reluctance drive in which both switches of a phase conduct together. The control word also holds a per-output enable mask.

Top module: `pwm3_center_gen`

## Requirements
- R1: With a nonzero active period P loaded, `sync_out` is high for one clock at each period start, every 2P clocks. In single-update mode (control bit 0 = 0) it pulses at no other time.
- R2: In double-update mode (control register at address 4, bit 0 = 1), `sync_out` also pulses at the midpoint, P clocks after each start.
- R3: For a duty d with 0 < d < P, the phase's high side is active for 2d+1 consecutive clocks per period. The pulse begins P-d+1 clocks after the start pulse, so it is centered on the midpoint plus one register delay.
- R4: A duty of 0 keeps the high side inactive for the whole period. A duty of P or more keeps it active on every clock.
- R5: Duties are written at address 1 (A), 2 (B) and 3 (C). In single-update mode, a duty written during a period leaves that period unchanged and applies from the next start.
- R6: In double-update mode, a duty written in the first half of a period applies from the midpoint. The high-side on-time of that period is d_old + d_new + 1.
- R7: A period written at address 0 does not change the length of the period already running. It applies from the next start.
- R8: With `srm_n` high and both enables of a phase set, the low side is active exactly when the high side is inactive.
- R9: With `srm_n` low and both enables set, the low side of a phase is active exactly when its high side is active.
- R10: With `pol_hi` = 1, an active output is driven 1. With `pol_hi` = 0, every output pin is inverted, including the inactive level.
- R11: Control bits 1, 2 and 3 enable the high sides of A, B and C. Bits 4, 5 and 6 enable the low sides of A, B and C. An output whose bit is clear stays at its inactive level.
- R12: Reset clears the control word and all staged and active values. All outputs are then inactive, and `sync_out` is high on every clock until a nonzero period has been loaded.
- R13: Writes to addresses 5, 6 and 7 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W (3) | Register address: 0 period, 1-3 duty A-C, 4 control |
| wr_data | input | CNT_W (16) | Write data |
| pol_hi | input | 1 | 1: active-high outputs, 0: active-low outputs |
| srm_n | input | 1 | Low selects switched-reluctance drive |
| hi_out | output | 3 | High-side drives, bit 0 = A |
| lo_out | output | 3 | Low-side drives, bit 0 = A |
| sync_out | output | 1 | One-clock pulse at each register load point |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a 3-bit address. It programs periods from 1 to 50, so every full period, and each period in which a load lands mid-run, fits inside a short counting window. Periods of 1 and 2 drive the turnaround of the state machine through its shortest paths. Duties of 0, P-1, P and above P reach the clamped ends of the comparison.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } tb_state_e;

    localparam int N_PHASE     = 3;
    localparam int ADDR_PERIOD = 0;
    localparam int ADDR_DUTY0  = 1;
    localparam int ADDR_CTRL   = ADDR_DUTY0 + N_PHASE;
    localparam int CTRL_DBL    = 0;
    localparam int CTRL_HEN    = 1;
    localparam int CTRL_LEN    = CTRL_HEN + N_PHASE;
    localparam int CTRL_W      = CTRL_LEN + N_PHASE;

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             start_evt,
    output logic             mid_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tb_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        unique case (state_q)
            ST_HOLD: begin
                cnt_d = '0;
                if (per_act != '0) begin
                    state_d = ST_UP;
                    cnt_d   = ONE;
                end
            end
            ST_UP: begin
                if (per_act == '0) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end else if (cnt >= per_act) begin
                    cnt_d   = cnt - ONE;
                    state_d = (cnt == ONE) ? ST_UP : ST_DOWN;
                end else begin
                    cnt_d = cnt + ONE;
                end
            end
            ST_DOWN: begin
                cnt_d   = cnt - ONE;
                state_d = (cnt == ONE) ? ST_UP : ST_DOWN;
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // event outputs
    always_comb begin
        start_evt = (cnt == '0) && (state_q != ST_DOWN);
        mid_evt   = (state_q == ST_UP) && (per_act != '0) && (cnt == per_act);
    end

    p_fall_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |=> (cnt == $past(cnt) - ONE));

    p_top_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD && per_act != '0) |-> (cnt <= per_act));

    p_hold_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt == '0));

endmodule

// File: rtl/pwm3_regbank.sv
module pwm3_regbank
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic                            load_start,
    input  logic                            load_mid,
    output logic [CNT_W-1:0]                per_act,
    output logic [N_PHASE-1:0][CNT_W-1:0]   duty_act,
    output logic                            dbl_mode,
    output logic [N_PHASE-1:0]              en_hi,
    output logic [N_PHASE-1:0]              en_lo
);

    logic [CNT_W-1:0]              per_stg;
    logic [N_PHASE-1:0][CNT_W-1:0] duty_stg;
    logic [CTRL_W-1:0]             ctrl_q;

    // staged values and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_stg  <= '0;
            duty_stg <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_PERIOD)) per_stg <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_CTRL))   ctrl_q  <= wr_data[CTRL_W-1:0];
            for (int i = 0; i < N_PHASE; i++) begin
                if (wr_addr == ADDR_W'(ADDR_DUTY0 + i)) duty_stg[i] <= wr_data;
            end
        end
    end

    // active values, loaded at the timebase events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act  <= '0;
            duty_act <= '0;
        end else if (load_start) begin
            per_act  <= per_stg;
            duty_act <= duty_stg;
        end else if (load_mid && dbl_mode) begin
            duty_act <= duty_stg;
        end
    end

    always_comb begin
        dbl_mode = ctrl_q[CTRL_DBL];
        en_hi    = ctrl_q[CTRL_HEN +: N_PHASE];
        en_lo    = ctrl_q[CTRL_LEN +: N_PHASE];
    end

    p_period_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_start |=> $stable(per_act));

    p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_start && !load_mid) |=> $stable(duty_act));

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] duty,
    input  logic             srm_n,
    input  logic             en_hi,
    input  logic             en_lo,
    output logic             hi_q,
    output logic             lo_q
);

    logic conduct;

    always_comb begin
        conduct = (duty != '0) && ((duty >= per_act) || (cnt >= per_act - duty));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= conduct & en_hi;
            lo_q <= (srm_n ? ~conduct : conduct) & en_lo;
        end
    end

    p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !hi_q);

    p_comp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (srm_n && en_hi && en_lo) |=> (hi_q != lo_q));

    p_srm_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!srm_n && en_hi && en_lo) |=> (hi_q == lo_q));

endmodule

// File: rtl/pwm3_center_gen.sv
module pwm3_center_gen
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                pol_hi,
    input  logic                srm_n,
    output logic [N_PHASE-1:0]  hi_out,
    output logic [N_PHASE-1:0]  lo_out,
    output logic                sync_out
);

    logic [CNT_W-1:0]              cnt;
    logic [CNT_W-1:0]              per_act;
    logic [N_PHASE-1:0][CNT_W-1:0] duty_act;
    logic                          start_evt, mid_evt, dbl_mode;
    logic [N_PHASE-1:0]            en_hi, en_lo, hi_q, lo_q;

    pwm3_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_act   (per_act),
        .cnt       (cnt),
        .start_evt (start_evt),
        .mid_evt   (mid_evt)
    );

    pwm3_regbank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_start (start_evt),
        .load_mid   (mid_evt),
        .per_act    (per_act),
        .duty_act   (duty_act),
        .dbl_mode   (dbl_mode),
        .en_hi      (en_hi),
        .en_lo      (en_lo)
    );

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        pwm3_phase #(.CNT_W(CNT_W)) u_ph (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .per_act (per_act),
            .duty    (duty_act[g]),
            .srm_n   (srm_n),
            .en_hi   (en_hi[g]),
            .en_lo   (en_lo[g]),
            .hi_q    (hi_q[g]),
            .lo_q    (lo_q[g])
        );
    end

    always_comb begin
        hi_out   = hi_q ^ {N_PHASE{~pol_hi}};
        lo_out   = lo_q ^ {N_PHASE{~pol_hi}};
        sync_out = start_evt | (mid_evt & dbl_mode);
    end

    p_sync_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_evt && !dbl_mode) |-> !sync_out);

endmodule

// File: tb/pwm3_center_gen_bench.sv
module pwm3_center_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pol_hi = 1'b1;
    logic        srm_n = 1'b1;
    logic [2:0]  hi_out, lo_out;
    logic        sync_out;

    always #2 clk = ~clk;

    pwm3_center_gen u_pwm3_center_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pol_hi(pol_hi), .srm_n(srm_n),
        .hi_out(hi_out), .lo_out(lo_out), .sync_out(sync_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // measurement results
    int m_hc [3];
    int m_lc [3];
    int m_hp [3];
    int m_mism, m_nsync, m_sfirst, m_afirst;

    // columns: P, dA, dB, dC, dbl, expA, expB, expC, expSync
    localparam int VEC [8][9] = '{
        '{10,  3,  5,  9, 0,  7, 11, 19, 1},
        '{10,  0, 10, 12, 0,  0, 20, 20, 1},
        '{16,  1,  8, 15, 1,  3, 17, 31, 2},
        '{ 4,  2,  2,  2, 0,  5,  5,  5, 1},
        '{ 1,  0,  1,  2, 0,  0,  2,  2, 1},
        '{50, 25, 49,  0, 1, 51, 99,  0, 2},
        '{20,  7, 13, 20, 0, 15, 27, 40, 1},
        '{ 2,  1,  1,  3, 1,  3,  3,  4, 2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns one negedge later
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sync_out && n < 2000);
        chk(sync_out, "R1 sync seen", int'(sync_out), 1);
    endtask

    // positioned at the negedge of a sync cycle s; samples cycles s+1..s+win
    task automatic measure(input int win, input int w0a, input int w0d,
                           input int w1a, input int w1d);
        for (int i = 0; i < 3; i++) begin m_hc[i] = 0; m_lc[i] = 0; m_hp[i] = 0; end
        m_mism = 0; m_nsync = 0; m_sfirst = 0; m_afirst = 0;
        if (w0a >= 0) begin wr_en = 1'b1; wr_addr = 3'(w0a); wr_data = 16'(w0d); end
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (k == 1 && w1a >= 0) begin
                wr_en = 1'b1; wr_addr = 3'(w1a); wr_data = 16'(w1d);
            end
            for (int i = 0; i < 3; i++) begin
                if (hi_out[i] == pol_hi) m_hc[i]++;
                if (lo_out[i] == pol_hi) m_lc[i]++;
                if (hi_out[i]) m_hp[i]++;
                if (hi_out[i] != lo_out[i]) m_mism++;
            end
            if (hi_out[0] == pol_hi && m_afirst == 0) m_afirst = k;
            if (sync_out) begin
                m_nsync++;
                if (m_sfirst == 0) m_sfirst = k;
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic setup20();
        wr(4, 126); wr(0, 20); wr(1, 5); wr(2, 5); wr(3, 5);
        repeat (120) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state (R12)
        repeat (3) @(negedge clk);
        chk(hi_out == 3'b000, "R12 hi in reset", int'(hi_out), 0);
        chk(lo_out == 3'b000, "R12 lo in reset", int'(lo_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b1, "R12 sync held", int'(sync_out), 1);
        @(negedge clk);
        chk(sync_out == 1'b1, "R12 sync held 2", int'(sync_out), 1);
        chk(hi_out == 3'b000 && lo_out == 3'b000, "R12 outputs inactive",
            int'({hi_out, lo_out}), 0);

        // vector table: R1 R2 R3 R4 R8
        for (int v = 0; v < 8; v++) begin
            int p;
            p = VEC[v][0];
            wr(4, 126 + VEC[v][4]);
            wr(0, p); wr(1, VEC[v][1]); wr(2, VEC[v][2]); wr(3, VEC[v][3]);
            repeat (250) @(negedge clk);
            wait_start();
            measure(2 * p, -1, 0, -1, 0);
            for (int i = 0; i < 3; i++) begin
                chk(m_hc[i] == VEC[v][5 + i], "R3 R4 high on-time", m_hc[i], VEC[v][5 + i]);
                chk(m_lc[i] == 2 * p - VEC[v][5 + i], "R8 low complement", m_lc[i],
                    2 * p - VEC[v][5 + i]);
            end
            chk(m_nsync == VEC[v][8], "R1 R2 sync count", m_nsync, VEC[v][8]);
            if (VEC[v][4] == 0) begin
                chk(m_sfirst == 2 * p, "R1 sync spacing", m_sfirst, 2 * p);
                if (VEC[v][1] > 0 && VEC[v][1] < p)
                    chk(m_afirst == p - VEC[v][1] + 1, "R3 pulse start", m_afirst,
                        p - VEC[v][1] + 1);
            end else begin
                chk(m_sfirst == p, "R2 midpoint sync", m_sfirst, p);
            end
        end

        // R5: single-update write lands on the next period
        setup20();
        wait_start();
        measure(40, 1, 12, -1, 0);
        chk(m_hc[0] == 11, "R5 current period kept", m_hc[0], 11);
        measure(40, -1, 0, -1, 0);
        chk(m_hc[0] == 25, "R5 next period uses new duty", m_hc[0], 25);

        // R6: double-update write splits the period
        setup20();
        wait_start();
        measure(40, 4, 127, 1, 12);
        chk(m_hc[0] == 18, "R6 asymmetric period", m_hc[0], 18);
        measure(40, -1, 0, -1, 0);
        chk(m_hc[0] == 25, "R6 following period", m_hc[0], 25);

        // R7: period write waits for the next start
        setup20();
        wait_start();
        measure(40, 0, 30, -1, 0);
        chk(m_sfirst == 40, "R7 running period length", m_sfirst, 40);
        measure(60, -1, 0, -1, 0);
        chk(m_sfirst == 60, "R7 new period length", m_sfirst, 60);

        // R9: switched-reluctance pairing
        setup20();
        srm_n = 1'b0;
        repeat (4) @(negedge clk);
        wait_start();
        measure(40, -1, 0, -1, 0);
        chk(m_mism == 0, "R9 high equals low", m_mism, 0);
        chk(m_lc[0] == 11, "R9 low on-time", m_lc[0], 11);
        srm_n = 1'b1;

        // R10: inverted polarity
        pol_hi = 1'b0;
        repeat (4) @(negedge clk);
        wait_start();
        measure(40, -1, 0, -1, 0);
        chk(m_hc[0] == 11, "R10 active-low on-time", m_hc[0], 11);
        chk(m_hp[0] == 29, "R10 pin high count", m_hp[0], 29);
        pol_hi = 1'b1;

        // R11: high side of A masked
        wr(4, 124);
        repeat (60) @(negedge clk);
        wait_start();
        measure(40, -1, 0, -1, 0);
        chk(m_hc[0] == 0, "R11 masked high A", m_hc[0], 0);
        chk(m_lc[0] == 29, "R11 low A still driven", m_lc[0], 29);
        chk(m_hc[1] == 11, "R11 high B enabled", m_hc[1], 11);

        // R13: unused addresses
        wr(5, 0); wr(6, 0); wr(7, 0);
        repeat (60) @(negedge clk);
        wait_start();
        measure(40, -1, 0, -1, 0);
        chk(m_hc[1] == 11, "R13 duty B untouched", m_hc[1], 11);
        chk(m_lc[0] == 29, "R13 control untouched", m_lc[0], 29);
        chk(m_sfirst == 40, "R13 period untouched", m_sfirst, 40);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule